// File: doc/BRIEF.md
# Memory Array Supply Switch Sequencer

This block decides which of two supply rails powers a set of on-chip memory arrays: the memory rail or the core rail. Software writes the wanted rail into a mode register. The block then runs a fixed changeover. It first stops the array clocks, then moves the rail select, and then starts the clocks again. The length of each step comes from a packed delay register. The physical head switches and clock gates sit outside the block, and this block drives them only through `arr_clk_halt` and `arr_rail_core`.

Software polls a status register until the done code for the requested rail appears. A complete switch takes at most about a thousand clock cycles, so a timeout of several hundred microseconds leaves a wide margin.

The register port is a single-cycle write strobe with a combinational read by default. The three registers sit at byte offsets 0x2A8 (mode), 0x2AC (delays) and 0x2B0 (status).

Top module: `arraymux_ctrl`

## Requirements
- R1: After reset the rail select is the memory rail (`arr_rail_core`=0), the clock halt is low, the status is 0x00, and the mode and delay registers read 0.
- R2: Bit 1 of a write to the mode register (0x2A8) chooses the rail: 0x00 requests the memory rail and 0x02 requests the core rail. The mode register reads back with the choice in bit 1.
- R3: The status register (0x2B0) returns the status in bits 4:0 with zeros above. It reads 0x00 when settled on the memory rail and 0x03 when settled on the core rail, and `arr_status` shows the same code.
- R4: From the cycle after a mode write that asks for the other rail, until the switch completes, the status is the busy code 0x1F. The busy code is never 0x00 or 0x03.
- R5: The rail select changes only while the clock halt is asserted. The halt rises before the flip and falls after it.
- R6: The delay register holds four byte fields: select-switch in bits 7:0, resume in bits 15:8, halt in bits 23:16 and post-halt in bits 31:24. A field value d gives a phase of d+1 cycles. Counting from the mode-write edge as cycle 0, the halt rises at cycle H+2, the rail flips at cycle H+P+3, and the halt falls and the status settles at cycle H+P+S+R+5.
- R7: The delay register reads back exactly what was last written to it.
- R8: Writing the mode value of the rail already selected produces no clock-halt pulse, and the status stays at the done code.
- R9: Writes to the status register have no effect, and reads of any unmapped offset return 0.
- R10: A mode write made during a switch does not cut that switch short. The switch in progress completes to the rail it started toward, and a second switch then follows to the newly written rail.
- R11: Changing one delay field by read-modify-write leaves the other three fields unchanged, and writes to other registers never change the delay register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe, one cycle per write |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| arr_clk_halt | output | 1 | Stops the memory array clocks while high |
| arr_rail_core | output | 1 | Rail select: 1 core rail, 0 memory rail |
| arr_status | output | 5 | Status code: 0x00, 0x03 or busy 0x1F |

## Verification
The properties assume that every write lasts exactly one cycle, with the address stable while the strobe is high. They also assume that reset is applied before any write. The bench drives all register accesses from one task that raises the strobe on a falling edge for a single rising edge, so both conditions always hold. The timer properties take it as given that software does not count on delay values changed in the middle of a switch. The bench therefore writes delays only while the block is settled. The exception is the queued-write scenario, which changes only the mode register.

// File: rtl/amx_pkg.sv
package amx_pkg;

   // Phases of one rail changeover
   typedef enum logic [2:0] {
      S_IDLE      = 3'd0,
      S_PRE_HALT  = 3'd1,
      S_POST_HALT = 3'd2,
      S_SWITCH    = 3'd3,
      S_RESUME    = 3'd4
   } amx_phase_e;

   // Field index inside the packed delay register (order fixed by layout)
   localparam int unsigned F_SEL    = 0;
   localparam int unsigned F_RESUME = 1;
   localparam int unsigned F_HALT   = 2;
   localparam int unsigned F_POST   = 3;
   localparam int unsigned N_FIELDS = 4;

endpackage

// File: rtl/amx_timer.sv
module amx_timer #(
   parameter int unsigned DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DLY_W-1:0] load_val,
   output logic             expired
);
   localparam logic [DLY_W-1:0] ONE = {{(DLY_W-1){1'b0}}, 1'b1};

   logic [DLY_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - ONE;
   end

   assign expired = (cnt_q == '0);

   // R6: a loaded value is taken exactly
   a_r6_load_taken: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == $past(load_val)));

   // R6: counting is one step per cycle, never wrapping below zero
   a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));

endmodule

// File: rtl/amx_seq.sv
module amx_seq
   import amx_pkg::*;
#(
   parameter int unsigned DLY_W     = 8,
   parameter int unsigned STS_W     = 5,
   parameter int unsigned BUSY_CODE = 'h1F,
   parameter int unsigned MEM_CODE  = 'h00,
   parameter int unsigned CORE_CODE = 'h03
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              mode_core,
   input  logic [N_FIELDS-1:0][DLY_W-1:0]    dly,
   output logic                              clk_halt,
   output logic                              rail_core,
   output logic [STS_W-1:0]                  status
);
   localparam logic [STS_W-1:0] BUSY_V = BUSY_CODE[STS_W-1:0];
   localparam logic [STS_W-1:0] MEM_V  = MEM_CODE[STS_W-1:0];
   localparam logic [STS_W-1:0] CORE_V = CORE_CODE[STS_W-1:0];

   if (BUSY_CODE == MEM_CODE || BUSY_CODE == CORE_CODE || MEM_CODE == CORE_CODE) begin : g_bad_codes
      $error("amx_seq: status codes must be distinct");
   end
   if (BUSY_CODE >= (1 << STS_W) || CORE_CODE >= (1 << STS_W)) begin : g_bad_width
      $error("amx_seq: status code does not fit STS_W");
   end

   amx_phase_e       state_q, state_d;
   logic             halt_q, rail_q, target_q;
   logic             load, set_halt, clr_halt, flip, capture;
   logic [DLY_W-1:0] load_val;
   logic             expired;
   logic             busy;

   amx_timer #(.DLY_W(DLY_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .expired  (expired)
   );

   always_comb begin
      state_d  = state_q;
      load     = 1'b0;
      load_val = '0;
      set_halt = 1'b0;
      clr_halt = 1'b0;
      flip     = 1'b0;
      capture  = 1'b0;
      unique case (state_q)
         S_IDLE: if (mode_core != rail_q) begin
            state_d  = S_PRE_HALT;
            load     = 1'b1;
            load_val = dly[F_HALT];
            capture  = 1'b1;
         end
         S_PRE_HALT: if (expired) begin
            state_d  = S_POST_HALT;
            load     = 1'b1;
            load_val = dly[F_POST];
            set_halt = 1'b1;
         end
         S_POST_HALT: if (expired) begin
            state_d  = S_SWITCH;
            load     = 1'b1;
            load_val = dly[F_SEL];
            flip     = 1'b1;
         end
         S_SWITCH: if (expired) begin
            state_d  = S_RESUME;
            load     = 1'b1;
            load_val = dly[F_RESUME];
         end
         S_RESUME: if (expired) begin
            state_d  = S_IDLE;
            clr_halt = 1'b1;
         end
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         halt_q   <= 1'b0;
         rail_q   <= 1'b0;
         target_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (capture)       target_q <= mode_core;
         if (set_halt)      halt_q   <= 1'b1;
         else if (clr_halt) halt_q   <= 1'b0;
         if (flip)          rail_q   <= target_q;
      end
   end

   assign busy      = (state_q != S_IDLE) || (mode_core != rail_q);
   assign status    = busy ? BUSY_V : (rail_q ? CORE_V : MEM_V);
   assign clk_halt  = halt_q;
   assign rail_core = rail_q;

   // R5: the rail moves only under a halt that was already in place
   a_r5_flip_under_halt: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rail_q) |-> (halt_q && $past(halt_q)));

   // R5: the halt rises while the rail is still at its old value
   a_r5_halt_before_flip: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halt_q) |-> $stable(rail_q));

   // R4: a done code is never shown while clocks are halted
   a_r4_busy_while_halted: assert property (@(posedge clk) disable iff (!rst_n)
      halt_q |-> (status == BUSY_V));

   // R8: settled with a matching request gives no halt next cycle
   a_r8_no_idle_halt: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_IDLE && mode_core == rail_q) |=> !halt_q);

endmodule

// File: rtl/amx_regs.sv
module amx_regs
   import amx_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned DLY_W    = 8,
   parameter int unsigned STS_W    = 5,
   parameter int unsigned MODE_BIT = 1,
   parameter int unsigned MODE_OFS = 'h2A8,
   parameter int unsigned DLY_OFS  = 'h2AC,
   parameter int unsigned STS_OFS  = 'h2B0,
   parameter bit          RD_REG   = 1'b0
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we,
   input  logic [ADDR_W-1:0]              addr,
   input  logic [DATA_W-1:0]              wdata,
   output logic [DATA_W-1:0]              rdata,
   input  logic [STS_W-1:0]               status_in,
   output logic                           mode_core,
   output logic [N_FIELDS-1:0][DLY_W-1:0] dly_fields
);
   localparam int unsigned DLY_BITS = N_FIELDS * DLY_W;

   if (DLY_BITS > DATA_W) begin : g_bad_dly
      $error("amx_regs: delay fields exceed data width");
   end
   if (STS_W > DATA_W || MODE_BIT >= DATA_W) begin : g_bad_fields
      $error("amx_regs: field outside data width");
   end
   if (MODE_OFS >= (1 << ADDR_W) || DLY_OFS >= (1 << ADDR_W) || STS_OFS >= (1 << ADDR_W)) begin : g_bad_ofs
      $error("amx_regs: register offset does not fit ADDR_W");
   end

   logic                hit_mode, hit_dly, hit_sts;
   logic                mode_q;
   logic [DLY_BITS-1:0] dly_q;
   logic [DATA_W-1:0]   rd_next;

   assign hit_mode = (addr == MODE_OFS[ADDR_W-1:0]);
   assign hit_dly  = (addr == DLY_OFS[ADDR_W-1:0]);
   assign hit_sts  = (addr == STS_OFS[ADDR_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         dly_q  <= '0;
      end else if (we) begin
         if (hit_mode) mode_q <= wdata[MODE_BIT];
         if (hit_dly)  dly_q  <= wdata[DLY_BITS-1:0];
      end
   end

   for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
      assign dly_fields[i] = dly_q[i*DLY_W +: DLY_W];
   end

   always_comb begin
      rd_next = '0;
      if (hit_mode)     rd_next[MODE_BIT]       = mode_q;
      else if (hit_dly) rd_next[DLY_BITS-1:0]   = dly_q;
      else if (hit_sts) rd_next[STS_W-1:0]      = status_in;
   end

   if (RD_REG) begin : g_rd_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rdata <= '0;
         else        rdata <= rd_next;
      end
   end else begin : g_rd_comb
      assign rdata = rd_next;
   end

   assign mode_core = mode_q;

   // R11: delays change only on a write aimed at the delay register
   a_r11_dly_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && hit_dly) |=> $stable(dly_q));

   // R9: the mode changes only on a write aimed at the mode register
   a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && hit_mode) |=> $stable(mode_q));

endmodule

// File: rtl/arraymux_ctrl.sv
module arraymux_ctrl
   import amx_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned DLY_W    = 8,
   parameter int unsigned STS_W    = 5,
   parameter bit          RD_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   output logic              arr_clk_halt,
   output logic              arr_rail_core,
   output logic [STS_W-1:0]  arr_status
);
   logic                           mode_core;
   logic [N_FIELDS-1:0][DLY_W-1:0] dly_fields;

   amx_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .DLY_W  (DLY_W),
      .STS_W  (STS_W),
      .RD_REG (RD_REG)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (cfg_we),
      .addr       (cfg_addr),
      .wdata      (cfg_wdata),
      .rdata      (cfg_rdata),
      .status_in  (arr_status),
      .mode_core  (mode_core),
      .dly_fields (dly_fields)
   );

   amx_seq #(
      .DLY_W (DLY_W),
      .STS_W (STS_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_core (mode_core),
      .dly       (dly_fields),
      .clk_halt  (arr_clk_halt),
      .rail_core (arr_rail_core),
      .status    (arr_status)
   );

endmodule

// File: tb/arraymux_ctrl_test.sv
module arraymux_ctrl_test;
   localparam logic [11:0] A_MODE = 12'h2A8;
   localparam logic [11:0] A_DLY  = 12'h2AC;
   localparam logic [11:0] A_STS  = 12'h2B0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [11:0] cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        arr_clk_halt, arr_rail_core;
   logic [4:0]  arr_status;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   arraymux_ctrl uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .arr_clk_halt(arr_clk_halt),
      .arr_rail_core(arr_rail_core), .arr_status(arr_status)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(posedge clk);
      #1 cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      check(arr_rail_core == 1'b0, "R1 rail", arr_rail_core, 0);
      check(arr_clk_halt == 1'b0, "R1 halt", arr_clk_halt, 0);
      check(arr_status == 5'h00, "R1 status port", arr_status, 0);
      rd(A_MODE, v); check(v == 0, "R1 mode reg", v, 0);
      rd(A_DLY, v);  check(v == 0, "R1 delay reg", v, 0);
      rd(A_STS, v);  check(v == 0, "R1 R3 status reg", v, 0);
   endtask

   task automatic t_delay_rw();
      logic [31:0] v;
      wr(A_DLY, 32'h1122_3344);
      rd(A_DLY, v); check(v == 32'h1122_3344, "R7 readback", v, 32'h1122_3344);
      // R11: change halt field (bits 23:16) only
      rd(A_DLY, v);
      v = (v & 32'hFF00_FFFF) | 32'h00AB_0000;
      wr(A_DLY, v);
      rd(A_DLY, v); check(v == 32'h11AB_3344, "R11 rmw", v, 32'h11AB_3344);
      wr(A_MODE, 32'h0);
      rd(A_DLY, v); check(v == 32'h11AB_3344, "R11 other write", v, 32'h11AB_3344);
   endtask

   task automatic t_status_ro();
      logic [31:0] v;
      wr(A_STS, 32'hFFFF_FFFF);
      rd(A_STS, v); check(v == 32'h0, "R9 status write ignored", v, 0);
      check(arr_clk_halt == 1'b0 && arr_rail_core == 1'b0, "R9 no action", {arr_clk_halt, arr_rail_core}, 0);
      rd(A_DLY, v); check(v == 32'h11AB_3344, "R9 R11 delay kept", v, 32'h11AB_3344);
      rd(12'h000, v); check(v == 0, "R9 unmapped", v, 0);
      rd(12'h2B4, v); check(v == 0, "R9 unmapped", v, 0);
   endtask

   // R2 R3 R4 R5 R6
   task automatic t_switch(input int h, input int p, input int s, input int r, input bit core);
      int rise = -1, flip = -1, fall = -1;
      bit prev_rail;
      logic [31:0] v;
      logic [4:0] exp_code;
      exp_code = core ? 5'h03 : 5'h00;
      wr(A_DLY, {p[7:0], h[7:0], r[7:0], s[7:0]});
      prev_rail = arr_rail_core;
      wr(A_MODE, core ? 32'h2 : 32'h0);
      check(arr_status == 5'h1F, "R4 busy after write", arr_status, 5'h1F);
      for (int n = 1; n < 1200; n++) begin
         @(posedge clk); #1;
         if (arr_clk_halt && rise < 0) rise = n;
         if (arr_rail_core != prev_rail && flip < 0) begin
            flip = n;
            check(arr_clk_halt == 1'b1, "R5 flip under halt", arr_clk_halt, 1);
         end
         if (!arr_clk_halt && rise >= 0 && fall < 0) fall = n;
         if (fall < 0 && arr_status != 5'h1F)
            check(0, "R4 busy held", arr_status, 5'h1F);
         if (fall >= 0) break;
      end
      check(rise == h + 2, "R6 halt rise cycle", rise, h + 2);
      check(flip == h + p + 3, "R6 flip cycle", flip, h + p + 3);
      check(fall == h + p + s + r + 5, "R6 halt fall cycle", fall, h + p + s + r + 5);
      check(arr_rail_core == core, "R2 rail select", arr_rail_core, core);
      check(arr_status == exp_code, "R3 status port", arr_status, exp_code);
      rd(A_STS, v); check(v == {27'b0, exp_code}, "R3 status reg", v, exp_code);
      rd(A_MODE, v); check(v == (core ? 32'h2 : 32'h0), "R2 mode readback", v, core ? 2 : 0);
   endtask

   task automatic t_same_mode(input bit core);
      logic [4:0] exp_code;
      bit saw_halt = 1'b0, bad_sts = 1'b0;
      exp_code = core ? 5'h03 : 5'h00;
      wr(A_MODE, core ? 32'h2 : 32'h0);
      for (int n = 0; n < 40; n++) begin
         if (arr_clk_halt) saw_halt = 1'b1;
         if (arr_status != exp_code) bad_sts = 1'b1;
         @(posedge clk); #1;
      end
      check(!saw_halt, "R8 no halt pulse", saw_halt, 0);
      check(!bad_sts, "R8 status stays done", bad_sts, 0);
   endtask

   task automatic t_queued();
      int rises = 0;
      bit saw_core = 1'b0, prev_h = 1'b0;
      logic [31:0] v;
      wr(A_DLY, 32'h0303_0303);
      wr(A_MODE, 32'h2);
      repeat (3) @(posedge clk);
      #1;
      wr(A_MODE, 32'h0);
      for (int n = 0; n < 200; n++) begin
         @(posedge clk); #1;
         if (arr_clk_halt && !prev_h) rises++;
         prev_h = arr_clk_halt;
         if (arr_rail_core) saw_core = 1'b1;
      end
      check(saw_core, "R10 first switch completed", saw_core, 1);
      check(rises == 2, "R10 two halt pulses", rises, 2);
      check(arr_rail_core == 1'b0, "R10 final rail", arr_rail_core, 0);
      rd(A_STS, v); check(v == 0, "R10 final status", v, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_delay_rw();
      t_status_ro();
      t_switch(0, 0, 0, 0, 1'b1);
      t_same_mode(1'b1);
      t_switch(5, 2, 7, 3, 1'b0);
      t_same_mode(1'b0);
      t_switch(1, 9, 0, 4, 1'b1);
      t_switch(255, 255, 255, 255, 1'b0);
      t_queued();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule